// File: doc/BRIEF.md
# FIFO Retransmit Setup Controller

This block governs replay on the read side of a FIFO. A software-visible or board-level retransmit strobe (active low) is sampled on the read clock. When the strobe is first seen low, the block checks two preconditions. First, both the read enable and the write enable (active low) must be idle on the edge before and on the edge where the strobe is seen. Second, the number of words written since the last reset must lie inside the allowed window. If both checks pass, the block runs a fixed two-cycle setup. During setup it holds the read pointer at location zero and, in standard mode, forces the empty flag low. When setup ends it releases both controls. From then on the external flag logic compares the restored pointers again, and ordinary reads replay the stored words from the start.

A strobe that fails any check is refused. The block raises a one-cycle error pulse and leaves the pointer controls untouched. The memory array, the write side and the pointer comparison are outside this block. There is no data stream here, so there is no valid/ready interface and no back-pressure. Every pin is a plain control or status signal.

Top module: `fifo_rtx_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no strobe, `rptr_clear_o`, `empty_force_o` and `rtx_err_o` are all 0.
- R2: A request is recognised only on a rising edge where `rtx_strobe_n_i` is 0 after being 1 at the previous edge. A strobe held at 0 for several cycles causes exactly one request.
- R3: A request is accepted only if `rd_en_n_i` and `wr_en_n_i` are both 1 at the edge before the request edge and also at the request edge.
- R4: A request is accepted only if `words_written_i` is between 1 and D-2 inclusive. D is DEPTH when `fwft_mode_i`=0 and DEPTH+1 when `fwft_mode_i`=1.
- R5: After an accepted request edge, `rptr_clear_o` is 1 for exactly two cycles and then returns to 0.
- R6: `empty_force_o` is 1 in the same two cycles as `rptr_clear_o` if `fwft_mode_i` was 0 at the request edge, and stays 0 if it was 1.
- R7: A refused request gives `rtx_err_o`=1 for exactly the one cycle after the request edge, while `rptr_clear_o` and `empty_force_o` stay 0.
- R8: A new falling strobe seen during the setup cycles, including the edge that ends setup, is ignored. It raises no error and does not extend the setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| fwft_mode_i | input | 1 | 1 = first-word-fall-through timing, 0 = standard timing |
| rtx_strobe_n_i | input | 1 | Retransmit request, active low |
| rd_en_n_i | input | 1 | FIFO read enable, active low |
| wr_en_n_i | input | 1 | FIFO write enable, active low |
| words_written_i | input | CNT_W | Words written since the last reset |
| rptr_clear_o | output | 1 | Holds the read pointer at location zero |
| empty_force_o | output | 1 | Forces the empty flag to its empty state |
| rtx_err_o | output | 1 | One-cycle pulse when a request is refused |

## Verification
Suppose the sequencer's counter or state is wrong. The effect appears within three read-clock cycles of a request: `rptr_clear_o` is either too short, too long, or retriggered by a second falling strobe. Suppose instead the precondition stage holds a stale previous value of an enable or of the strobe. The edge that follows then gets the wrong verdict on the very next cycle: an unexpected error pulse, or a setup that should have been refused. The bench covers both edges of the count window in both timing modes, so an off-by-one in either limit changes the outcome of a single request.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef enum logic {
    RTX_IDLE  = 1'b0,
    RTX_SETUP = 1'b1
  } rtx_state_e;

  // fixed length of the setup period in read-clock cycles
  localparam int RTX_SETUP_CYCLES = 2;

  // largest allowed written-word count for a timing mode
  function automatic int rtx_max_words(input int depth, input logic fwft);
    return fwft ? depth - 1 : depth - 2;
  endfunction
endpackage

// File: rtl/rtx_input_stage.sv
module rtx_input_stage (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic strobe_n_i,
  input  logic rd_en_n_i,
  input  logic wr_en_n_i,
  output logic fall_o,
  output logic quiet_o
);
  logic strobe_q, rd_q, wr_q;

  // previous-edge samples; reset to the idle (high) levels
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      strobe_q <= 1'b1;
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
    end else begin
      strobe_q <= strobe_n_i;
      rd_q     <= rd_en_n_i;
      wr_q     <= wr_en_n_i;
    end
  end

  // request: strobe low now, high at the previous edge
  assign fall_o  = strobe_q & ~strobe_n_i;
  // both enables idle at the previous edge and at this one
  assign quiet_o = rd_q & wr_q & rd_en_n_i & wr_en_n_i;
endmodule

// File: rtl/rtx_count_window.sv
module rtx_count_window #(
  parameter int DEPTH = 16384,
  parameter int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic [CNT_W-1:0] words_i,
  input  logic             fwft_i,
  output logic             in_window_o
);
  import rtx_pkg::*;

  localparam logic [CNT_W-1:0] MAX_STD  = CNT_W'(rtx_max_words(DEPTH, 1'b0));
  localparam logic [CNT_W-1:0] MAX_FWFT = CNT_W'(rtx_max_words(DEPTH, 1'b1));

  logic [CNT_W-1:0] limit;
  logic             nonzero;

  assign limit       = fwft_i ? MAX_FWFT : MAX_STD;
  assign nonzero     = |words_i;
  assign in_window_o = nonzero && (words_i <= limit);
endmodule

// File: rtl/rtx_setup_seq.sv
module rtx_setup_seq #(
  parameter int SETUP_CYCLES = rtx_pkg::RTX_SETUP_CYCLES,
  localparam int CW = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic fall_i,
  input  logic quiet_i,
  input  logic in_window_i,
  input  logic fwft_i,
  output logic rptr_clear_o,
  output logic empty_force_o,
  output logic err_o
);
  import rtx_pkg::*;

  rtx_state_e    state_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q       <= RTX_IDLE;
      left_q        <= '0;
      rptr_clear_o  <= 1'b0;
      empty_force_o <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state_q)
        RTX_IDLE: begin
          if (fall_i) begin
            if (quiet_i && in_window_i) begin
              state_q       <= RTX_SETUP;
              left_q        <= CW'(SETUP_CYCLES - 1);
              rptr_clear_o  <= 1'b1;
              empty_force_o <= ~fwft_i;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        RTX_SETUP: begin
          // strobes are not looked at while setup runs
          if (left_q == '0) begin
            state_q       <= RTX_IDLE;
            rptr_clear_o  <= 1'b0;
            empty_force_o <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: state_q <= RTX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_rtx_ctrl.sv
module fifo_rtx_ctrl #(
  parameter int DEPTH = 16384,
  parameter int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             fwft_mode_i,
  input  logic             rtx_strobe_n_i,
  input  logic             rd_en_n_i,
  input  logic             wr_en_n_i,
  input  logic [CNT_W-1:0] words_written_i,
  output logic             rptr_clear_o,
  output logic             empty_force_o,
  output logic             rtx_err_o
);
  logic fall, quiet, in_window;

  rtx_input_stage u_in (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .strobe_n_i (rtx_strobe_n_i),
    .rd_en_n_i  (rd_en_n_i),
    .wr_en_n_i  (wr_en_n_i),
    .fall_o     (fall),
    .quiet_o    (quiet)
  );

  rtx_count_window #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_win (
    .words_i     (words_written_i),
    .fwft_i      (fwft_mode_i),
    .in_window_o (in_window)
  );

  rtx_setup_seq u_seq (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .fall_i        (fall),
    .quiet_i       (quiet),
    .in_window_i   (in_window),
    .fwft_i        (fwft_mode_i),
    .rptr_clear_o  (rptr_clear_o),
    .empty_force_o (empty_force_o),
    .err_o         (rtx_err_o)
  );
endmodule

// File: rtl/fifo_rtx_ctrl_chk.sv
module fifo_rtx_ctrl_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             rtx_strobe_n_i,
  input logic [CNT_W-1:0] words_written_i,
  input logic             rptr_clear_o,
  input logic             empty_force_o,
  input logic             rtx_err_o
);
  // R7: refusal never overlaps a setup
  assert_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rtx_err_o |-> !rptr_clear_o && !empty_force_o);

  // R7: error lasts a single cycle
  assert_err_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rtx_err_o |=> !rtx_err_o);

  // R5: setup lasts at least two cycles
  assert_setup_min_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rptr_clear_o) |=> rptr_clear_o);

  // R5 / R8: setup lasts no more than two cycles
  assert_setup_max_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rptr_clear_o && $past(rptr_clear_o)) |=> !rptr_clear_o);

  // R6: the empty override only appears inside setup
  assert_empty_in_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    empty_force_o |-> rptr_clear_o);

  // R4: an empty FIFO can never start a setup
  assert_zero_count_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!rptr_clear_o && !rtx_strobe_n_i && $past(rtx_strobe_n_i) && words_written_i == '0)
      |=> !rptr_clear_o);

  // R2: a setup starts only from a strobe seen low
  assert_start_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rptr_clear_o) |-> !$past(rtx_strobe_n_i));
endmodule

bind fifo_rtx_ctrl fifo_rtx_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_n_i         (rst_n_i),
  .rtx_strobe_n_i  (rtx_strobe_n_i),
  .words_written_i (words_written_i),
  .rptr_clear_o    (rptr_clear_o),
  .empty_force_o   (empty_force_o),
  .rtx_err_o       (rtx_err_o)
);

// File: tb/fifo_rtx_ctrl_tb_top.sv
module fifo_rtx_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft = 1'b0;
  logic strobe_n = 1'b1;
  logic ren_n = 1'b1;
  logic wen_n = 1'b1;
  logic [CNT_W-1:0] words = '0;
  logic clr, emp, err;

  int checks = 0;
  int failures = 0;
  logic [2:0] q_exp[$];
  string      q_tag[$];
  bit         done = 1'b0;

  // reference state built from the requirements
  bit m_prev_rt = 1'b1, m_prev_ren = 1'b1, m_prev_wen = 1'b1;
  int m_left = 0;
  bit m_std = 1'b0;

  always #5 clk = ~clk;

  fifo_rtx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .fwft_mode_i     (fwft),
    .rtx_strobe_n_i  (strobe_n),
    .rd_en_n_i       (ren_n),
    .wr_en_n_i       (wen_n),
    .words_written_i (words),
    .rptr_clear_o    (clr),
    .empty_force_o   (emp),
    .rtx_err_o       (err)
  );

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {clr,emp,err} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: set inputs for the next edge and push the expected outputs after it
  task automatic step(input bit rt, input bit rn, input bit wn, input int cnt, input string tag);
    bit fall, quiet, win, e_err;
    int lim;
    @(negedge clk); #1;
    strobe_n = rt; ren_n = rn; wen_n = wn; words = CNT_W'(cnt);
    fall  = m_prev_rt && !rt;
    quiet = m_prev_ren && m_prev_wen && rn && wn;
    lim   = fwft ? DEPTH - 1 : DEPTH - 2;
    win   = (cnt >= 1) && (cnt <= lim);
    e_err = 1'b0;
    if (m_left > 0) m_left--;
    else if (fall) begin
      if (quiet && win) begin m_left = 2; m_std = !fwft; end
      else e_err = 1'b1;
    end
    q_exp.push_back({m_left > 0, (m_left > 0) && m_std, e_err});
    q_tag.push_back(tag);
    m_prev_rt = rt; m_prev_ren = rn; m_prev_wen = wn;
  endtask

  task automatic request(input bit rn_b, input bit wn_b, input bit rn_a, input bit wn_a,
                         input int cnt, input string tag);
    step(1, rn_b, wn_b, cnt, tag);
    step(0, rn_a, wn_a, cnt, tag);
    for (int i = 0; i < 3; i++) step(1, 1, 1, cnt, tag);
  endtask

  // monitor: compare one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) check3({clr, emp, err}, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #5000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #22;
    check3({clr, emp, err}, 3'b000, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) step(1, 1, 1, 5, "R1 idle");
    // accepted standard-mode setup, strobe held low for several cycles
    step(1, 1, 1, 5, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 5, "R2 held low");
    for (int i = 0; i < 2; i++) step(1, 1, 1, 5, "R6");
    // enables not idle
    request(1, 0, 1, 1, 5, "R3 wen before");
    request(0, 1, 1, 1, 5, "R3 ren before");
    request(1, 1, 0, 1, 5, "R3 ren at edge");
    request(1, 1, 1, 0, 5, "R3 wen at edge");
    // count window, standard mode
    request(1, 1, 1, 1, 0,  "R4 zero R7");
    request(1, 1, 1, 1, 1,  "R4 one");
    request(1, 1, 1, 1, 14, "R4 std max");
    request(1, 1, 1, 1, 15, "R4 std over");
    // first-word-fall-through mode
    fwft = 1'b1;
    request(1, 1, 1, 1, 15, "R4 fwft max R6");
    request(1, 1, 1, 1, 16, "R4 fwft over");
    fwft = 1'b0;
    // second strobe during setup
    step(1, 1, 1, 7, "R8");
    step(0, 1, 1, 7, "R8");
    step(1, 1, 1, 7, "R8");
    step(0, 1, 1, 7, "R8 ignored");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 7, "R8 after");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule